// File: doc/BRIEF.md
# Repeated-Bit Read Lane (Transmit and Receive Pair)

This block is the transmit and receive pair for one read data lane of a memory interface. It can stretch each data bit over a selectable number of lane cycles. At full rate every bit occupies a single unit interval, which leaves very little sampling margin. Right after a wake from the deepest power state, the interface timing has not yet been recalibrated. During that window the power-mode controller can ask for a repetition factor Z. Each bit is then driven for Z consecutive lane cycles, so the usable sampling window grows in proportion to Z at the cost of bandwidth. The usual reduced setting is Z=2. The controller doubles Z again whenever a timing error is flagged.

The transmitter accepts a burst request together with a 2-bit log2 rate code. It takes eight 8-bit words, one at each word boundary, and shifts them out most significant bit first, repeating every bit Z times. The receiver starts on the same edge. It picks one sample from the middle of each Z-sample group, shifts the samples back into words and emits each recovered word with a one-cycle valid strobe. The rate is captured when a burst starts and cannot change until the burst is over. A request made while a burst is running is dropped.

Top module: `rep_lane_link`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `lane_out` and `rec_valid` are all low.
- R2: `rate_log2` selects Z = 1, 2, 4 or 8 for codes 0, 1, 2 or 3. The code is captured on the edge that accepts a burst, and changes to it during the burst have no effect on the lane or on the recovered words.
- R3: `burst_go` is accepted on an edge where `busy` is low. `busy` then stays high for exactly 64×Z cycles. A `burst_go` seen while `busy` is high is ignored and neither restarts nor lengthens the burst.
- R4: In cycle c after the accepting edge (c = 0 … 64Z−1), `lane_out` carries bit 7 − ((c / Z) mod 8) of word c / (8Z). Each bit is therefore held for Z cycles, words go out in order, and bit 7 goes first. `lane_out` is low whenever `busy` is low.
- R5: Word 0 is taken from `word_in` on the accepting edge. Word k (k = 1 … 7) is taken on the edge that ends cycle 8Zk − 1. `word_in` is ignored on every other edge. A word taken while `word_valid` is low is sent as all zeros.
- R6: Within each Z-cycle group, the receiver uses the sample at index Z/2 (index 0 when Z=1), counting from 0 at the group's first cycle. A corrupted sample at any other index of a group, such as index 0 or index Z−1 for Z ≥ 4, or index 0 for Z = 2, has no effect on the recovered word.
- R7: `rec_valid` is a single-cycle pulse. For word k it is high in cycle 8Zk + 7Z + Z/2 + 1 after the accepting edge, so there are exactly 8 pulses per burst.
- R8: When `lane_in` follows `lane_out`, `rec_word` during each `rec_valid` pulse equals the word sent in that slot, for every value of Z.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Lane clock, one cycle per unit interval |
| rst | input | 1 | Synchronous active-high reset |
| burst_go | input | 1 | Request to start a burst |
| rate_log2 | input | 2 | log2 of the repetition factor Z |
| word_in | input | 8 | Parallel word to transmit |
| word_valid | input | 1 | Qualifies `word_in`; a word taken while low is sent as zero |
| lane_out | output | 1 | Serial transmit lane |
| lane_in | input | 1 | Serial receive lane (oversampled, one sample per cycle) |
| rec_word | output | 8 | Recovered word |
| rec_valid | output | 1 | One-cycle strobe marking a new `rec_word` |
| busy | output | 1 | High while a burst is being transmitted |

## Verification
The assertions watch, on every cycle, the quantities that depend only on the burst timing. They check that `busy` rises on an accepted request and lasts exactly 64×Z cycles, that the lane is low when idle and does not change inside a bit group, and that `rec_valid` never lasts two cycles. Data correctness can only be shown by the bench's scenarios, because it depends on the words the bench chose. These scenarios cover serial bit order, word sampling at the right edges, zero substitution for invalid words, and recovery when an edge sample of each group is flipped. The bench also covers changes of `rate_log2` and stray `burst_go` pulses during a burst.

// File: rtl/rep_lane_pkg.sv
package rep_lane_pkg;

    parameter int WORD_W    = 8;
    parameter int BURST_LEN = 8;
    parameter int ZLOG_W    = 2;

    localparam int ZLOG_MAX = (1 << ZLOG_W) - 1;
    localparam int Z_MAX    = 1 << ZLOG_MAX;
    localparam int SMP_W    = (ZLOG_MAX > 0) ? ZLOG_MAX : 1;
    localparam int BIT_W    = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int WRD_W    = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam int SPAN_W   = $clog2(BURST_LEN * WORD_W * Z_MAX) + 1;

    typedef logic [ZLOG_W-1:0] zlog_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic [WRD_W-1:0] wrd;
        logic [BIT_W-1:0] bitn;
        logic [SMP_W-1:0] smp;
    } slot_pos_t;

    typedef struct packed {
        logic  vld;
        word_t data;
    } rx_word_t;

    typedef enum logic [1:0] {
        TX_HOLD,
        TX_SHIFT,
        TX_LOAD,
        TX_CLEAR
    } tx_act_e;

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
    localparam logic [WRD_W-1:0] LAST_WRD = WRD_W'(BURST_LEN - 1);

    function automatic logic [SMP_W-1:0] last_smp(zlog_t zl);
        return SMP_W'((32'd1 << zl) - 32'd1);
    endfunction

    function automatic logic [SMP_W-1:0] centre_smp(zlog_t zl);
        return SMP_W'((32'd1 << zl) >> 1);
    endfunction

endpackage

// File: rtl/rep_lane_slot_seq.sv
module rep_lane_slot_seq
    import rep_lane_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  zlog_t     zlog_in,
    output logic      active,
    output slot_pos_t pos,
    output zlog_t     zlog,
    output logic      grp_end,
    output logic      bit_end,
    output logic      burst_end
);

    always_comb begin
        grp_end   = active && (pos.smp == last_smp(zlog));
        bit_end   = grp_end && (pos.bitn == LAST_BIT);
        burst_end = bit_end && (pos.wrd == LAST_WRD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            pos    <= '0;
            zlog   <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                pos    <= '0;
                zlog   <= zlog_in;
            end
        end else if (burst_end) begin
            active <= 1'b0;
            pos    <= '0;
        end else if (bit_end) begin
            pos.smp  <= '0;
            pos.bitn <= '0;
            pos.wrd  <= pos.wrd + 1'b1;
        end else if (grp_end) begin
            pos.smp  <= '0;
            pos.bitn <= pos.bitn + 1'b1;
        end else begin
            pos.smp <= pos.smp + 1'b1;
        end
    end

endmodule

// File: rtl/rep_lane_tx.sv
module rep_lane_tx
    import rep_lane_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  zlog_t zlog_in,
    input  word_t word_in,
    input  logic  word_vld,
    output logic  busy,
    output logic  launch,
    output logic  lane
);

    slot_pos_t pos;
    zlog_t     zlog;
    logic      grp_end, bit_end, burst_end;
    word_t     shreg;
    word_t     fresh;
    tx_act_e   act;

    rep_lane_slot_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (go),
        .zlog_in   (zlog_in),
        .active    (busy),
        .pos       (pos),
        .zlog      (zlog),
        .grp_end   (grp_end),
        .bit_end   (bit_end),
        .burst_end (burst_end)
    );

    always_comb begin
        launch = go && !busy;
        fresh  = word_vld ? word_in : '0;
        if (launch)                   act = TX_LOAD;
        else if (burst_end)           act = TX_CLEAR;
        else if (bit_end)             act = TX_LOAD;
        else if (grp_end)             act = TX_SHIFT;
        else                          act = TX_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else begin
            unique case (act)
                TX_LOAD:  shreg <= fresh;
                TX_SHIFT: shreg <= {shreg[WORD_W-2:0], 1'b0};
                TX_CLEAR: shreg <= '0;
                default:  shreg <= shreg;
            endcase
        end
    end

    assign lane = busy && shreg[WORD_W-1];

endmodule

// File: rtl/rep_lane_rx.sv
module rep_lane_rx
    import rep_lane_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  zlog_t    zlog_in,
    input  logic     lane_in,
    output rx_word_t out
);

    logic      active;
    slot_pos_t pos;
    zlog_t     zlog;
    logic      grp_end, bit_end, burst_end;
    logic      take;
    word_t     acc;
    word_t     acc_nxt;

    rep_lane_slot_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .zlog_in   (zlog_in),
        .active    (active),
        .pos       (pos),
        .zlog      (zlog),
        .grp_end   (grp_end),
        .bit_end   (bit_end),
        .burst_end (burst_end)
    );

    always_comb begin
        take    = active && (pos.smp == centre_smp(zlog));
        acc_nxt = {acc[WORD_W-2:0], lane_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            out.vld  <= 1'b0;
            out.data <= '0;
        end else begin
            out.vld <= 1'b0;
            if (take) begin
                acc <= acc_nxt;
                if (pos.bitn == LAST_BIT) begin
                    out.data <= acc_nxt;
                    out.vld  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rep_lane_link.sv
module rep_lane_link
    import rep_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              burst_go,
    input  logic [ZLOG_W-1:0] rate_log2,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_valid,
    output logic              lane_out,
    input  logic              lane_in,
    output logic [WORD_W-1:0] rec_word,
    output logic              rec_valid,
    output logic              busy
);

    logic     launch;
    rx_word_t rx_out;

    rep_lane_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .go       (burst_go),
        .zlog_in  (rate_log2),
        .word_in  (word_in),
        .word_vld (word_valid),
        .busy     (busy),
        .launch   (launch),
        .lane     (lane_out)
    );

    rep_lane_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .start   (launch),
        .zlog_in (rate_log2),
        .lane_in (lane_in),
        .out     (rx_out)
    );

    assign rec_word  = rx_out.data;
    assign rec_valid = rx_out.vld;

endmodule

// File: rtl/rep_lane_link_chk.sv
module rep_lane_link_chk
    import rep_lane_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              burst_go,
    input logic [ZLOG_W-1:0] rate_log2,
    input logic              busy,
    input logic              lane_out,
    input logic              rec_valid
);

    logic [SPAN_W-1:0] cnt;
    zlog_t             zl;
    logic [SPAN_W-1:0] span_last;
    logic [SPAN_W-1:0] phase_mask;

    always_comb begin
        span_last  = SPAN_W'((BURST_LEN * WORD_W) << zl) - 1'b1;
        phase_mask = SPAN_W'((32'd1 << zl) - 32'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            zl  <= '0;
        end else if (burst_go && !busy) begin
            cnt <= '0;
            zl  <= rate_log2;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!busy && !lane_out && !rec_valid));

    p_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (burst_go && !busy) |=> busy);

    p_busy_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != span_last) |=> busy);

    p_busy_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == span_last) |=> !busy);

    p_idle_low_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !lane_out);

    p_bit_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && (cnt & phase_mask) != '0) |-> $stable(lane_out));

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rec_valid |=> !rec_valid);

endmodule

bind rep_lane_link rep_lane_link_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .burst_go  (burst_go),
    .rate_log2 (rate_log2),
    .busy      (busy),
    .lane_out  (lane_out),
    .rec_valid (rec_valid)
);

// File: tb/test_rep_lane_link.sv
module test_rep_lane_link;

    logic       clk = 1'b0;
    logic       rst;
    logic       burst_go;
    logic [1:0] rate_log2;
    logic [7:0] word_in;
    logic       word_valid;
    logic       lane_out;
    logic       lane_in;
    logic [7:0] rec_word;
    logic       rec_valid;
    logic       busy;
    logic       flip;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    assign lane_in = lane_out ^ flip;

    rep_lane_link i_rep_lane_link (
        .clk        (clk),
        .rst        (rst),
        .burst_go   (burst_go),
        .rate_log2  (rate_log2),
        .word_in    (word_in),
        .word_valid (word_valid),
        .lane_out   (lane_out),
        .lane_in    (lane_in),
        .rec_word   (rec_word),
        .rec_valid  (rec_valid),
        .busy       (busy)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    function automatic bit exp_lane(input logic [7:0] w, input int c, input int z);
        return w[7 - ((c / z) % 8)];
    endfunction

    // cmode: 0 clean, 1 flip sample 0 of each group, 2 flip sample Z-1
    task automatic run_burst(input int zl, input int cmode, input logic [7:0] drop,
                             input bit poke, input bit wobble);
        int z;
        int ctr;
        int cidx;
        int busy_err;
        int lane_err;
        int vld_err;
        int nvld;
        logic [7:0] w [8];
        z    = 1 << zl;
        ctr  = z / 2;
        cidx = (cmode == 1) ? 0 : z - 1;
        for (int i = 0; i < 8; i++) w[i] = 8'($urandom);
        busy_err = 0; lane_err = 0; vld_err = 0; nvld = 0;
        @(negedge clk);
        burst_go   = 1'b1;
        rate_log2  = 2'(zl);
        word_in    = w[0];
        word_valid = !drop[0];
        flip       = 1'b0;
        @(posedge clk);
        for (int c = 0; c < 64 * z + z + 1; c++) begin
            int  off;
            int  k;
            int  nk;
            bit  ev;
            bit  el;
            logic [7:0] ew;
            @(negedge clk);
            // R3 busy window
            if (busy !== (c < 64 * z)) busy_err++;
            // R4 serial format, R5 word capture and zero fill
            k  = c / (8 * z);
            el = 1'b0;
            if (c < 64 * z) el = drop[k] ? 1'b0 : exp_lane(w[k], c, z);
            if (lane_out !== el) lane_err++;
            // R7 strobe timing, R6/R8 recovered data
            off = c - (7 * z + ctr + 1);
            ev  = (off >= 0) && (off % (8 * z) == 0) && (off / (8 * z) < 8);
            if (rec_valid !== ev) vld_err++;
            if (ev && rec_valid) begin
                nvld++;
                ew = drop[off / (8 * z)] ? 8'h00 : w[off / (8 * z)];
                chk(rec_word == ew,
                    $sformatf("R8 R6 R5 word %0d Z=%0d corrupt=%0d", off / (8 * z), z, cmode),
                    rec_word, ew);
            end
            // drive next cycle
            burst_go  = poke && (c == 5);
            rate_log2 = (wobble || poke) ? 2'($urandom) : 2'(zl);
            nk = (c + 1) / (8 * z);
            if (((c + 1) % (8 * z) == 0) && nk < 8) begin
                word_in    = w[nk];
                word_valid = !drop[nk];
            end else begin
                word_in    = 8'($urandom);
                word_valid = 1'($urandom);
            end
            flip = (cmode != 0) && (c < 64 * z) && ((c % z) == cidx);
        end
        flip     = 1'b0;
        burst_go = 1'b0;
        chk(busy_err == 0, $sformatf("R3 busy window Z=%0d", z), busy_err, 0);
        chk(lane_err == 0, $sformatf("R4 lane bits Z=%0d", z), lane_err, 0);
        chk(vld_err == 0 && nvld == 8, $sformatf("R7 strobe count Z=%0d", z), nvld, 8);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R3 watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h2c41));
        rst = 1'b1; burst_go = 1'b0; rate_log2 = '0; word_in = '0;
        word_valid = 1'b0; flip = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0,      "R1 busy after reset",  busy, 0);
        chk(lane_out == 1'b0,  "R1 lane after reset",  lane_out, 0);
        chk(rec_valid == 1'b0, "R1 valid after reset", rec_valid, 0);

        // R2: every rate code, clean lane
        for (int zl = 0; zl < 4; zl++) run_burst(zl, 0, 8'h00, 1'b0, 1'b0);
        // R6: edge samples corrupted
        run_burst(1, 1, 8'h00, 1'b0, 1'b0);
        run_burst(2, 2, 8'h00, 1'b0, 1'b0);
        run_burst(2, 1, 8'h00, 1'b0, 1'b0);
        run_burst(3, 2, 8'h00, 1'b0, 1'b0);
        // R5 zero fill, R3 ignored request, R2 rate wobble
        run_burst(0, 0, 8'hA5, 1'b1, 1'b1);
        run_burst(2, 1, 8'h18, 1'b1, 1'b1);
        run_burst(3, 1, 8'h81, 1'b1, 1'b0);

        for (int n = 0; n < 10; n++) begin
            int zl;
            int cm;
            zl = int'($urandom % 4);
            cm = (zl == 0) ? 0 : (zl == 1) ? int'($urandom % 2) : int'($urandom % 3);
            run_burst(zl, cm, (($urandom % 3) == 0) ? 8'($urandom) : 8'h00,
                      1'($urandom), 1'($urandom));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule